// File: doc/BRIEF.md
# Serial Byte Receiver with Pulse-Width Framing Reset

This block receives the serial input of a display module. The input has three wires: a serial clock, a serial data line and an active-low framing reset line. There is no chip select. All three wires are brought into a fast system clock domain through two-flop synchronizers. A data bit is captured on each falling edge of the serial clock, so the sender changes data on the rising edge (clock idle low, sampling on the second edge). Bits arrive most significant first. Every eighth bit completes a byte, which appears on an 8-bit output together with a one-cycle valid strobe.

With no select line, the sender and the receiver can only get back into step through the reset line. The block counts how many system cycles the line stays low and sorts the pulse by its width. A very short pulse is treated as noise and has no effect. A pulse of medium width discards the partly received byte when the line goes high again. A long pulse clears all receiver state as soon as the long threshold is crossed, while the line is still low. Both thresholds are derived from the system clock frequency. The pulse counter saturates and does not wrap. Each action is also reported on its own one-cycle output pulse.

Top module: `serial_byte_rx`

## Requirements
- R1: On each falling edge of `ser_clk`, the value of `ser_dat` is shifted in. The eighth bit completes a byte, first bit in bit 7 and last bit in bit 0. The byte appears on `rx_byte` together with a `byte_valid` pulse that lasts exactly one system cycle, no later than four system cycles after the falling edge.
- R2: Framing runs continuously with no select input. After a byte completes, the next falling edge starts a new byte. Bits are never lost or reused between bytes.
- R3: A low pulse on `ser_rst_n` shorter than `SHORT_US` microseconds of system cycles has no effect. No action pulse is produced, and the bits of a partial byte are kept.
- R4: A low pulse of at least `SHORT_US` but less than `LONG_US` produces one `soft_clear` pulse after the line goes high. The partial byte is discarded, and `rx_byte` and `rx_active` are kept.
- R5: When the line has been low for `LONG_US`, one `full_reset` pulse is produced while the line is still low. It clears `rx_byte` to 0, clears `rx_active` and discards the partial byte. Releasing the line afterwards produces no `soft_clear`.
- R6: Falling edges of `ser_clk` that arrive while `ser_rst_n` is low are ignored.
- R7: `rx_active` goes high when the first byte completes. It stays high until a full reset or a system reset.
- R8: After the synchronous system reset `rst_n`, every output is 0.
- R9: The pulse-width counter saturates. A low pulse of any length, however far beyond the long threshold, produces exactly one `full_reset`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the serial clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ser_clk | input | 1 | Serial clock, idle low |
| ser_dat | input | 1 | Serial data, captured on the falling edge of ser_clk |
| ser_rst_n | input | 1 | Active-low framing reset line, decoded by pulse width |
| rx_byte | output | 8 | Last completed byte |
| byte_valid | output | 1 | One-cycle strobe when rx_byte updates |
| rx_active | output | 1 | Set by the first byte, cleared only by a full reset |
| soft_clear | output | 1 | One-cycle pulse when a medium pulse flushes the partial byte |
| full_reset | output | 1 | One-cycle pulse when a long pulse clears all state |

## Verification
The hardest case to reach from the ports is a partial byte that must survive or be discarded across a reset pulse. The serial clock can also toggle during that pulse. The stimulus sends a random number of bits, then applies a random glitch or a medium pulse, sometimes with serial clock edges inside the low window. A bench model tracks which bits should still be pending, so the next completed byte shows whether the partial bits were kept. Long pulses are directed. Each one is checked while the line is still low, and again after being held far past the threshold to show that the counter saturates.

// File: rtl/sbr_pkg.sv
// Shared types and helpers for the serial byte receiver.
// Assumes the system clock frequency is given in Hz.
package sbr_pkg;

    // Synchronized view of the three serial wires.
    typedef struct packed {
        logic rst_l;
        logic dat;
        logic clk_l;
    } line_t;

    // Number of system cycles in a span of microseconds.
    function automatic longint cycles_for_us(input longint hz, input longint us);
        return (hz * us) / 64'd1_000_000;
    endfunction

endpackage

// File: rtl/sbr_sync.sv
// Multi-bit two-flop synchronizer. Each bit is independent.
// Assumes the inputs are quasi-static relative to clk (no bus coherency needed).
module sbr_sync #(
    parameter int          WIDTH     = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic meta_q;
            logic sync_q;

            // Two-stage capture of one asynchronous wire.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[i];
                    sync_q <= RST_VAL[i];
                end else begin
                    meta_q <= d_async[i];
                    sync_q <= meta_q;
                end
            end

            assign q_sync[i] = sync_q;
        end
    endgenerate

endmodule

// File: rtl/sbr_rst_timer.sv
// Measures the low time of the synchronized framing reset line and classifies it.
// Medium pulse: soft_clr pulse on release. Long pulse: full_clr pulse once the
// long threshold is reached, while still low. Short pulses are ignored.
// Assumes SHORT_CYC < LONG_CYC.
module sbr_rst_timer #(
    parameter int SHORT_CYC = 50,
    parameter int LONG_CYC  = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_line,
    output logic soft_clr,
    output logic full_clr
);

    localparam int CNT_W = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);
    localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(LONG_CYC - 1);

    logic [CNT_W-1:0] low_cnt;

    // Count low cycles with saturation and emit the classified action pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            soft_clr <= 1'b0;
            full_clr <= 1'b0;
        end else begin
            soft_clr <= 1'b0;
            full_clr <= 1'b0;
            if (!rst_line) begin
                if (low_cnt < LONG_V) low_cnt <= low_cnt + 1'b1;
                if (low_cnt == LAST_V) full_clr <= 1'b1;
            end else begin
                if (low_cnt >= SHORT_V && low_cnt < LONG_V) soft_clr <= 1'b1;
                low_cnt <= '0;
            end
        end
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= LONG_V);
    p_actions_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({soft_clr, full_clr}));
    p_soft_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |-> $past(rst_line));
    p_full_while_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full_clr |-> !$past(rst_line));

endmodule

// File: rtl/sbr_shift.sv
// Detects falling edges of the synchronized serial clock and assembles bytes,
// MSB first. It ignores edges while the reset line is low. A soft clear drops
// the partial byte. A full clear also drops the last byte and the active flag.
// Assumes clk is at least 8x the serial clock, so edges are at least 2 cycles apart.
module sbr_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              sda,
    input  logic              line_low,
    input  logic              soft_clr,
    input  logic              full_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              byte_valid,
    output logic              rx_active
);

    localparam int BC_W = $clog2(DATA_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

    logic              sck_prev;
    logic              fall;
    logic [DATA_W-2:0] shift_q;
    logic [BC_W-1:0]   bit_cnt;

    // Previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck;
    end

    assign fall = sck_prev && !sck && !line_low;

    // Shift, count and publish bytes; the clear requests take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q    <= '0;
            bit_cnt    <= '0;
            rx_byte    <= '0;
            byte_valid <= 1'b0;
            rx_active  <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (full_clr) begin
                shift_q   <= '0;
                bit_cnt   <= '0;
                rx_byte   <= '0;
                rx_active <= 1'b0;
            end else if (soft_clr) begin
                shift_q <= '0;
                bit_cnt <= '0;
            end else if (fall) begin
                if (bit_cnt == LAST_BIT) begin
                    rx_byte    <= {shift_q, sda};
                    byte_valid <= 1'b1;
                    rx_active  <= 1'b1;
                    bit_cnt    <= '0;
                    shift_q    <= '0;
                end else begin
                    shift_q <= {shift_q[DATA_W-3:0], sda};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
    p_hold_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_low && !soft_clr && !full_clr) |=> $stable(bit_cnt) && !byte_valid);
    p_full_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full_clr |=> (rx_byte == '0 && !rx_active && bit_cnt == '0));
    p_active_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_active && !full_clr) |=> rx_active);

endmodule

// File: rtl/serial_byte_rx.sv
// Top level of the serial byte receiver. It synchronizes the three serial wires,
// times the framing reset line, and assembles bytes on falling serial clock edges.
// Assumes clk >= 8x ser_clk. Thresholds are derived from CLK_HZ.
module serial_byte_rx
    import sbr_pkg::*;
#(
    parameter longint CLK_HZ   = 250_000_000,
    parameter int     SHORT_US = 50,
    parameter int     LONG_US  = 2000,
    parameter int     DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_rst_n,
    output logic [DATA_W-1:0] rx_byte,
    output logic              byte_valid,
    output logic              rx_active,
    output logic              soft_clear,
    output logic              full_reset
);

    localparam int SHORT_CYC = int'(cycles_for_us(CLK_HZ, longint'(SHORT_US)));
    localparam int LONG_CYC  = int'(cycles_for_us(CLK_HZ, longint'(LONG_US)));
    localparam int LINE_W    = $bits(line_t);

    line_t raw_lines;
    line_t sync_lines;

    assign raw_lines = '{rst_l: ser_rst_n, dat: ser_dat, clk_l: ser_clk};

    sbr_sync #(
        .WIDTH   (LINE_W),
        .RST_VAL (LINE_W'(3'b100))
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_lines),
        .q_sync  (sync_lines)
    );

    sbr_rst_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_line (sync_lines.rst_l),
        .soft_clr (soft_clear),
        .full_clr (full_reset)
    );

    sbr_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck        (sync_lines.clk_l),
        .sda        (sync_lines.dat),
        .line_low   (!sync_lines.rst_l),
        .soft_clr   (soft_clear),
        .full_clr   (full_reset),
        .rx_byte    (rx_byte),
        .byte_valid (byte_valid),
        .rx_active  (rx_active)
    );

endmodule

// File: tb/serial_byte_rx_tb.sv
// Self-checking bench: random bit streams and reset pulses against a bench model.
module serial_byte_rx_tb;

    localparam int SHORT_C = 50;
    localparam int LONG_C  = 2000;
    localparam int HALF    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_rst_n = 1'b1;
    logic [7:0] rx_byte;
    logic       byte_valid, rx_active, soft_clear, full_reset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int         n_valid = 0, n_soft = 0, n_full = 0;
    logic [7:0] last_byte = 8'h00;
    int         max_valid_run = 0, valid_run = 0;

    // bench model
    logic [7:0] m_sh = 8'h00;
    int         m_cnt = 0;
    int         e_valid = 0, e_soft = 0, e_full = 0;
    logic [7:0] e_byte = 8'h00;
    logic       e_active = 1'b0;

    always #2 clk = ~clk;

    serial_byte_rx #(
        .CLK_HZ   (1_000_000),
        .SHORT_US (SHORT_C),
        .LONG_US  (LONG_C),
        .DATA_W   (8)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_dat    (ser_dat),
        .ser_rst_n  (ser_rst_n),
        .rx_byte    (rx_byte),
        .byte_valid (byte_valid),
        .rx_active  (rx_active),
        .soft_clear (soft_clear),
        .full_reset (full_reset)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                n_valid++;
                last_byte = rx_byte;
                valid_run++;
                if (valid_run > max_valid_run) max_valid_run = valid_run;
            end else valid_run = 0;
            if (soft_clear) n_soft++;
            if (full_reset) n_full++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] model_push(input logic [7:0] sh, input logic b);
        return {sh[6:0], b};
    endfunction

    // One bit: data changes with the rising edge, is captured on the falling edge.
    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_dat = b;
        ser_clk = 1'b1;
        wait_cyc(HALF);
        ser_clk = 1'b0;
        wait_cyc(HALF);
        m_sh = model_push(m_sh, b);
        m_cnt++;
        if (m_cnt == 8) begin
            m_cnt = 0;
            e_valid++;
            e_byte = m_sh;
            e_active = 1'b1;
            check(n_valid == e_valid, "R2", "byte count", n_valid, e_valid);
            check(last_byte == e_byte, "R1", "byte value", last_byte, e_byte);
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic check_state(input string req);
        check(n_soft == e_soft, req, "soft_clear count", n_soft, e_soft);
        check(n_full == e_full, req, "full_reset count", n_full, e_full);
        check(rx_byte == e_byte, req, "rx_byte", rx_byte, e_byte);
        check(rx_active == e_active, req, "rx_active", rx_active, e_active);
    endtask

    // Low pulse of n cycles with no serial activity, classified by the model.
    task automatic pulse(input int n, input bit toggle_inside);
        @(negedge clk);
        ser_rst_n = 1'b0;
        if (toggle_inside && n >= 20) begin
            wait_cyc(3);
            for (int k = 0; k < 3; k++) begin
                ser_dat = ~ser_dat;
                ser_clk = 1'b1; wait_cyc(2);
                ser_clk = 1'b0; wait_cyc(2);
            end
            wait_cyc(n - 15);
        end else wait_cyc(n);
        ser_rst_n = 1'b1;
        wait_cyc(8);
        if (n >= LONG_C) begin
            e_full++; m_cnt = 0; m_sh = 0; e_byte = 8'h00; e_active = 1'b0;
        end else if (n >= SHORT_C) begin
            e_soft++; m_cnt = 0; m_sh = 0;
        end
    endtask

    // Watchdog.
    initial begin
        #(4 * 200_000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        wait_cyc(5);
        // R8: reset state
        check(rx_byte == 0 && !byte_valid && !rx_active && !soft_clear && !full_reset,
              "R8", "outputs in reset", {rx_byte, byte_valid, rx_active, soft_clear, full_reset}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(4);
        check_state("R8");

        // R1/R7: directed bytes, MSB first
        send_byte(8'hA5);
        check(rx_active == 1'b1, "R7", "active after first byte", rx_active, 1);
        send_byte(8'h01);
        send_byte(8'h80);
        send_byte(8'hFF);
        send_byte(8'h00);

        // R3 with R6: glitch that also carries serial edges; partial bits kept
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        pulse(30, 1'b1);
        check_state("R3");
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        check_state("R6");

        // R4: medium pulse drops partial byte, keeps last byte and active flag
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        pulse(300, 1'b1);
        check_state("R4");
        send_byte(8'h3C);

        // R5: long pulse, checked while still low
        send_bit(1'b0); send_bit(1'b1);
        @(negedge clk);
        ser_rst_n = 1'b0;
        wait_cyc(LONG_C + 10);
        check(n_full == e_full + 1, "R5", "full_reset while low", n_full, e_full + 1);
        check(rx_byte == 0 && rx_active == 0, "R5", "cleared while low", {rx_byte, rx_active}, 0);
        // R9: keep holding far past the threshold
        wait_cyc(3 * LONG_C);
        ser_rst_n = 1'b1;
        wait_cyc(8);
        e_full++; m_cnt = 0; m_sh = 0; e_byte = 8'h00; e_active = 1'b0;
        check_state("R9");
        send_byte(8'hC3);

        // Constrained random mix of bits, glitches and medium pulses
        for (int it = 0; it < 60; it++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 6) begin
                int nb;
                nb = $urandom_range(1, 20);
                for (int j = 0; j < nb; j++) send_bit(1'($urandom_range(0, 1)));
            end else if (sel < 8) begin
                pulse($urandom_range(1, SHORT_C - 15), 1'($urandom_range(0, 1)));
                check_state("R3");
            end else begin
                pulse($urandom_range(SHORT_C + 10, LONG_C - 200), 1'($urandom_range(0, 1)));
                check_state("R4");
            end
        end
        // flush to a byte boundary and confirm framing
        while (m_cnt != 0) send_bit(1'($urandom_range(0, 1)));
        check_state("R2");

        check(max_valid_run <= 1, "R1", "byte_valid width", max_valid_run, 1);

        // R8: system reset mid-stream clears everything
        send_bit(1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);
        check(rx_byte == 0 && rx_active == 0, "R8", "after system reset", {rx_byte, rx_active}, 0);
        m_cnt = 0; m_sh = 0; e_byte = 0; e_active = 0;
        send_byte(8'h96);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule